// File: doc/BRIEF.md
# Trigger sum combiner with runtime-loaded lookup tables

This block merges a vector of condition flags into three trigger sums for the sequencer state that is currently active. The flags come from match terms, range checks, edge detectors and timer expirations. The three sums are named capture, hit and else. Each sum is an arbitrary Boolean function of the flags: any mix of AND, OR, XOR and inversion. The function is held in a two-level tree of lookup tables. A group of leaf tables each takes four flags, and one root table combines the leaf outputs. Because the function is only table contents, it can be changed at runtime without rebuilding the logic. Every state has its own three sums, so the combining function may differ from one state to the next.

Host software reprograms the tables with two commands. The select command picks one programming chain. The data command shifts a 32-bit word into the chosen chain, one bit position per bit, with the most significant bit first. There is one chain for each pair of state and sum kind. A chain that is never loaded keeps its all-zero reset contents, so its sum stays false. Software therefore programs only the sums of the states it uses.

Each clock, the block takes the flag vector and the state index. One cycle later it presents the three registered sum bits for that sample.

Top module: `trig_sum_combiner`

## Requirements
- R1: After reset every chain holds all zeros and no chain is selected. All three sum outputs read 0, and any sum whose chain is never loaded stays 0 for every flag pattern.
- R2: A select command (`cfgSelValid` high) stores `cfgSelIdx` as the target chain. The chain number is state*3 + kind, where capture is kind 0, hit is kind 1 and else is kind 2. Any value of NUM_STATES*3 or more means that no chain is selected. The selection holds until the next select command.
- R3: A data command (`cfgDataValid` high) shifts the 32-bit `cfgData` into the selected chain, MSB first. The chain moves up by 32 places and the word fills the low end. Bits pushed past the top of the 80-bit chain are lost. Chain layout: bits 79:64 are the root table, and bits 16g+15:16g are leaf table g.
- R4: A data command while no chain is selected changes no table.
- R5: Leaf table g outputs its bit at the index given by condFlags[4g+3:4g]. The root table outputs its bit at the index {leaf3, leaf2, leaf1, leaf0}, and that bit is the sum.
- R6: Each state uses its own three chains. Loading one chain leaves the sums of every other chain unchanged.
- R7: The sums for the flags and state index sampled at a rising edge appear on the outputs just after that edge and hold for one cycle. A change of input between edges does not reach the outputs until the next edge.
- R8: A state index of NUM_STATES or more gives 0 on all three sums.
- R9: When a select command and a data command arrive in the same cycle, the word is shifted into the newly selected chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSelValid | input | 1 | Select-chain command strobe |
| cfgSelIdx | input | 8 | Chain number to select (state*3 + kind) |
| cfgDataValid | input | 1 | Shift-data command strobe |
| cfgData | input | 32 | Word shifted into the selected chain, MSB first |
| condFlags | input | NUM_FLAGS (16) | Condition flags for the current sample |
| stateIdx | input | STATE_W (2) | Index of the active sequencer state |
| sumCapture | output | 1 | Registered capture sum of the active state |
| sumHit | output | 1 | Registered hit sum of the active state |
| sumElse | output | 1 | Registered else sum of the active state |

## Verification
The sum outputs are due exactly one rising edge after the flags and state index are sampled. The bench therefore changes inputs on a falling edge and reads the sums on the next falling edge. One directed test also looks at the outputs between those edges, to confirm that they have not moved early. A configuration command changes a table at the edge where it is sampled, so every table load is finished at least one full cycle before the next evaluation that depends on it.

// File: rtl/trig_sum_pkg.sv
package trig_sum_pkg;

  localparam int CFG_WORD_W = 32;
  localparam int SEL_W      = 8;
  localparam int LUT_IN     = 4;
  localparam int LUT_BITS   = 1 << LUT_IN;
  localparam int SUM_KINDS  = 3;

  typedef enum logic [1:0] {
    SUM_CAPTURE = 2'd0,
    SUM_HIT     = 2'd1,
    SUM_ELSE    = 2'd2
  } sum_kind_e;

  typedef struct packed {
    logic                  shift;
    logic [SEL_W-1:0]      chain;
    logic [CFG_WORD_W-1:0] word;
  } cfg_strobe_t;

endpackage

// File: rtl/trig_sum_lut_tree.sv
module trig_sum_lut_tree
  import trig_sum_pkg::*;
#(
  parameter int NUM_FLAGS = 16
) (
  input  logic [NUM_FLAGS/LUT_IN*LUT_BITS + (1 << (NUM_FLAGS/LUT_IN)) - 1:0] tableBits,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 result
);

  localparam int GROUPS  = NUM_FLAGS / LUT_IN;
  localparam int ROOT_W  = 1 << GROUPS;
  localparam int CHAIN_W = GROUPS * LUT_BITS + ROOT_W;

  logic [GROUPS-1:0] leafOut;
  logic [ROOT_W-1:0] rootTable;

  for (genvar g = 0; g < GROUPS; g++) begin : g_leaf
    logic [LUT_BITS-1:0] leafTable;
    logic [LUT_IN-1:0]   leafIdx;
    assign leafTable  = tableBits[g*LUT_BITS +: LUT_BITS];
    assign leafIdx    = flags[g*LUT_IN +: LUT_IN];
    assign leafOut[g] = leafTable[leafIdx];
  end

  assign rootTable = tableBits[CHAIN_W-1 -: ROOT_W];
  assign result    = rootTable[leafOut];

endmodule

// File: rtl/trig_sum_ctrl.sv
module trig_sum_ctrl
  import trig_sum_pkg::*;
#(
  parameter int NUM_CHAINS = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgSelValid,
  input  logic [SEL_W-1:0]      cfgSelIdx,
  input  logic                  cfgDataValid,
  input  logic [CFG_WORD_W-1:0] cfgData,
  output cfg_strobe_t           strobe
);

  localparam logic [SEL_W-1:0] NO_CHAIN  = '1;
  localparam logic [SEL_W-1:0] CHAIN_CNT = SEL_W'(NUM_CHAINS);

  logic [SEL_W-1:0] selReg;
  logic [SEL_W-1:0] effChain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= NO_CHAIN;
    end else if (cfgSelValid) begin
      selReg <= cfgSelIdx;
    end
  end

  // A select arriving with data steers that same word
  assign effChain = cfgSelValid ? cfgSelIdx : selReg;

  always_comb begin
    strobe.shift = cfgDataValid && (effChain < CHAIN_CNT);
    strobe.chain = effChain;
    strobe.word  = cfgData;
  end

endmodule

// File: rtl/trig_sum_datapath.sv
module trig_sum_datapath
  import trig_sum_pkg::*;
#(
  parameter int NUM_FLAGS  = 16,
  parameter int NUM_STATES = 3,
  parameter int STATE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfg_strobe_t          strobe,
  input  logic [NUM_FLAGS-1:0] condFlags,
  input  logic [STATE_W-1:0]   stateIdx,
  output logic [SUM_KINDS-1:0] sums
);

  localparam int GROUPS     = NUM_FLAGS / LUT_IN;
  localparam int ROOT_W     = 1 << GROUPS;
  localparam int CHAIN_W    = GROUPS * LUT_BITS + ROOT_W;
  localparam int NUM_CHAINS = NUM_STATES * SUM_KINDS;

  logic [CHAIN_W-1:0]   chainMem   [NUM_CHAINS];
  logic [CHAIN_W-1:0]   chainNext  [NUM_CHAINS];
  logic [CHAIN_W-1:0]   curTables  [SUM_KINDS];
  logic [SUM_KINDS-1:0] sumComb;
  logic                 stateOk;

  // Table storage: one shift chain per (state, kind)
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    if (CHAIN_W > CFG_WORD_W) begin : g_long
      assign chainNext[c] = {chainMem[c][CHAIN_W-CFG_WORD_W-1:0], strobe.word};
    end else begin : g_short
      assign chainNext[c] = strobe.word[CHAIN_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chainMem[c] <= '0;
      end else if (strobe.shift && (strobe.chain == SEL_W'(c))) begin
        chainMem[c] <= chainNext[c];
      end
    end
  end

  // Pick the tables of the active state
  always_comb begin
    stateOk = 1'b0;
    for (int k = 0; k < SUM_KINDS; k++) begin
      curTables[k] = '0;
    end
    for (int s = 0; s < NUM_STATES; s++) begin
      if (stateIdx == STATE_W'(s)) begin
        stateOk = 1'b1;
        for (int k = 0; k < SUM_KINDS; k++) begin
          curTables[k] = chainMem[s*SUM_KINDS + k];
        end
      end
    end
  end

  for (genvar k = 0; k < SUM_KINDS; k++) begin : g_eval
    logic treeOut;
    trig_sum_lut_tree #(
      .NUM_FLAGS(NUM_FLAGS)
    ) u_tree (
      .tableBits(curTables[k]),
      .flags    (condFlags),
      .result   (treeOut)
    );
    assign sumComb[k] = treeOut && stateOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sums <= '0;
    end else begin
      sums <= sumComb;
    end
  end

endmodule

// File: rtl/trig_sum_combiner.sv
module trig_sum_combiner
  import trig_sum_pkg::*;
#(
  parameter int NUM_FLAGS  = 16,
  parameter int NUM_STATES = 3,
  parameter int STATE_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgSelValid,
  input  logic [SEL_W-1:0]      cfgSelIdx,
  input  logic                  cfgDataValid,
  input  logic [CFG_WORD_W-1:0] cfgData,
  input  logic [NUM_FLAGS-1:0]  condFlags,
  input  logic [STATE_W-1:0]    stateIdx,
  output logic                  sumCapture,
  output logic                  sumHit,
  output logic                  sumElse
);

  localparam int NUM_CHAINS = NUM_STATES * SUM_KINDS;

  cfg_strobe_t          ctrlStrobe;
  logic [SUM_KINDS-1:0] sumVec;

  trig_sum_ctrl #(
    .NUM_CHAINS(NUM_CHAINS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgSelValid (cfgSelValid),
    .cfgSelIdx   (cfgSelIdx),
    .cfgDataValid(cfgDataValid),
    .cfgData     (cfgData),
    .strobe      (ctrlStrobe)
  );

  trig_sum_datapath #(
    .NUM_FLAGS (NUM_FLAGS),
    .NUM_STATES(NUM_STATES),
    .STATE_W   (STATE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (ctrlStrobe),
    .condFlags(condFlags),
    .stateIdx (stateIdx),
    .sums     (sumVec)
  );

  assign sumCapture = sumVec[SUM_CAPTURE];
  assign sumHit     = sumVec[SUM_HIT];
  assign sumElse    = sumVec[SUM_ELSE];

endmodule

// File: rtl/trig_sum_combiner_chk.sv
module trig_sum_combiner_chk
  import trig_sum_pkg::*;
#(
  parameter int NUM_FLAGS  = 16,
  parameter int NUM_STATES = 3,
  parameter int STATE_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgSelValid,
  input logic [SEL_W-1:0]     cfgSelIdx,
  input logic                 cfgDataValid,
  input logic [NUM_FLAGS-1:0] condFlags,
  input logic [STATE_W-1:0]   stateIdx,
  input logic                 shiftStrobe,
  input logic                 sumCapture,
  input logic                 sumHit,
  input logic                 sumElse
);

  localparam logic [SEL_W-1:0] CHAIN_CNT = SEL_W'(NUM_STATES * SUM_KINDS);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1: first sampled cycle after reset shows all sums low
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> ({sumCapture, sumHit, sumElse} == 3'b000));

  // R3: no table ever shifts without a data command
  p_shift_needs_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    shiftStrobe |-> cfgDataValid);

  // R4: an out-of-range select blocks the accompanying data word
  p_deselect_blocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSelValid && (cfgSelIdx >= CHAIN_CNT)) |-> !shiftStrobe);

  // R8: an unknown state index yields zero sums next cycle
  p_oob_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateIdx >= STATE_W'(NUM_STATES)) |=> ({sumCapture, sumHit, sumElse} == 3'b000));

  // R7: steady inputs and tables give steady registered sums
  p_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(shiftStrobe) && $stable(condFlags) && $stable(stateIdx))
    |=> ($stable(sumCapture) && $stable(sumHit) && $stable(sumElse)));

endmodule

bind trig_sum_combiner trig_sum_combiner_chk #(
  .NUM_FLAGS (NUM_FLAGS),
  .NUM_STATES(NUM_STATES),
  .STATE_W   (STATE_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgSelValid (cfgSelValid),
  .cfgSelIdx   (cfgSelIdx),
  .cfgDataValid(cfgDataValid),
  .condFlags   (condFlags),
  .stateIdx    (stateIdx),
  .shiftStrobe (ctrlStrobe.shift),
  .sumCapture  (sumCapture),
  .sumHit      (sumHit),
  .sumElse     (sumElse)
);

// File: tb/tb_trig_sum_combiner.sv
module tb_trig_sum_combiner;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSelValid = 1'b0;
  logic [7:0]  cfgSelIdx = '0;
  logic        cfgDataValid = 1'b0;
  logic [31:0] cfgData = '0;
  logic [15:0] condFlags = '0;
  logic [1:0]  stateIdx = '0;
  logic        sumCapture, sumHit, sumElse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_sum_combiner dut (
    .clk(clk), .rstN(rstN),
    .cfgSelValid(cfgSelValid), .cfgSelIdx(cfgSelIdx),
    .cfgDataValid(cfgDataValid), .cfgData(cfgData),
    .condFlags(condFlags), .stateIdx(stateIdx),
    .sumCapture(sumCapture), .sumHit(sumHit), .sumElse(sumElse)
  );

  // {flags, state, expected {capture, hit, else}}
  // s0: capture=f0, hit=f5^f12, else=!(f2&f3); s1: capture unloaded, hit=f8&f9, else=1
  localparam logic [20:0] VEC [NUM_VEC] = '{
    {16'h0001, 2'd0, 3'b101},
    {16'h1000, 2'd0, 3'b011},
    {16'h000C, 2'd0, 3'b000},
    {16'h1021, 2'd0, 3'b101},
    {16'h0300, 2'd1, 3'b011},
    {16'h0100, 2'd1, 3'b001},
    {16'hFFFF, 2'd2, 3'b000},
    {16'hFFFF, 2'd3, 3'b000},
    {16'hFFFF, 2'd0, 3'b100},
    {16'h0020, 2'd0, 3'b011}
  };

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  // All command tasks begin and end on a falling edge
  task automatic sendSel(input logic [7:0] idx);
    cfgSelValid = 1'b1; cfgSelIdx = idx;
    @(negedge clk);
    cfgSelValid = 1'b0;
  endtask

  task automatic sendWord(input logic [31:0] w);
    cfgDataValid = 1'b1; cfgData = w;
    @(negedge clk);
    cfgDataValid = 1'b0;
  endtask

  // v = {root, leaf3, leaf2, leaf1, leaf0}
  task automatic loadChain(input logic [7:0] idx, input logic [79:0] v);
    sendSel(idx);
    sendWord({16'h0000, v[79:64]});
    sendWord(v[63:32]);
    sendWord(v[31:0]);
  endtask

  task automatic applyVec(input logic [15:0] f, input logic [1:0] s);
    condFlags = f; stateIdx = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: outputs low right after reset
    check("R1 reset outputs", {sumCapture, sumHit, sumElse}, 3'b000);
    applyVec(16'hFFFF, 2'd0);
    check("R1 unloaded chains read zero", {sumCapture, sumHit, sumElse}, 3'b000);

    loadChain(8'd0, {16'hAAAA, 16'h0000, 16'h0000, 16'h0000, 16'hAAAA});
    loadChain(8'd1, {16'h33CC, 16'hAAAA, 16'h0000, 16'hCCCC, 16'h0000});
    loadChain(8'd2, {16'hAAAA, 16'h0000, 16'h0000, 16'h0000, 16'h0FFF});
    loadChain(8'd4, {16'hF0F0, 16'h0000, 16'h8888, 16'h0000, 16'h0000});
    // R3: four words into an 80-bit chain, the first one falls off the top
    sendSel(8'd5);
    sendWord(32'h1234_5678);
    sendWord({16'h0000, 16'hFFFF});
    sendWord(32'h0);
    sendWord(32'h0);

    // R5 / R6 / R8 vector walk
    for (int i = 0; i < NUM_VEC; i++) begin
      logic [20:0] v;
      string tag;
      v = VEC[i];
      applyVec(v[20:5], v[4:3]);
      case (v[4:3])
        2'd0: tag = $sformatf("R5 vec%0d", i);
        2'd1: tag = $sformatf("R6 R3 vec%0d", i);
        2'd2: tag = $sformatf("R1 unloaded vec%0d", i);
        default: tag = $sformatf("R8 vec%0d", i);
      endcase
      check(tag, {sumCapture, sumHit, sumElse}, v[2:0]);
    end

    // R7: inputs changed between edges do not show until the next edge
    applyVec(16'h0001, 2'd0);
    check("R7 settled", {sumCapture, sumHit, sumElse}, 3'b101);
    condFlags = 16'h1000;
    #1;
    check("R7 no early change", {sumCapture, sumHit, sumElse}, 3'b101);
    @(negedge clk);
    check("R7 after edge", {sumCapture, sumHit, sumElse}, 3'b011);

    // R4 / R2: deselect, then shift ones; chain 0 must keep its table
    sendSel(8'd0);
    sendSel(8'd9);
    sendWord(32'hFFFF_FFFF);
    applyVec(16'h0001, 2'd0);
    check("R4 R2 deselected shift ignored", {sumCapture, sumHit, sumElse}, 3'b101);

    // R9: select and data in one cycle; word goes to chain 8 (s2 else)
    sendSel(8'd3);
    cfgSelValid = 1'b1; cfgSelIdx = 8'd8;
    cfgDataValid = 1'b1; cfgData = {16'h0000, 16'hFFFF};
    @(negedge clk);
    cfgSelValid = 1'b0; cfgDataValid = 1'b0;
    sendWord(32'h0);
    sendWord(32'h0);
    applyVec(16'h0000, 2'd2);
    check("R9 new chain loaded", {sumCapture, sumHit, sumElse}, 3'b001);
    applyVec(16'hFFFF, 2'd1);
    check("R9 R6 old chain untouched", {sumCapture, sumHit, sumElse}, 3'b011);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule